// File: doc/BRIEF.md
# Advanced Power Management Command and Status Port Pair

This block implements two byte-wide registers reached over a simple byte bus: a command port and a scratch status port, chosen by one address bit. Firmware and the operating system use the command port to hand power-management control back and forth. Two reserved command codes switch the interrupt-routing enable bit (SCI enable) of the power-management control register on or off. Every command write can also raise a system management interrupt (SMI) toward the processor when a configuration enable allows it.

The status port is plain storage that the two parties use to exchange a byte. The block keeps its own copy of the SCI enable bit and also sends one-cycle set and clear strobes, so that the control register elsewhere can follow it. The SMI output is a registered one-cycle pulse per qualifying write.

Top module: `apm_port`

## Requirements
- R1: After reset both ports read 0x00, and `sci_en_o`, `sci_set_o`, `sci_clr_o` and `smi_o` are all 0.
- R2: `sel_i` = 0 addresses the command port and `sel_i` = 1 the status port. `rdata_o` shows the last value written to the selected port, without delay, from the cycle after the write.
- R3: A command-port write of 0xF1 sets `sci_en_o` (bit 0 of the power-management control register) to 1 in the next cycle and raises `sci_set_o` for exactly that cycle.
- R4: A command-port write of 0xF0 clears `sci_en_o` to 0 in the next cycle and raises `sci_clr_o` for exactly that cycle.
- R5: A command-port write of any value other than 0xF0 and 0xF1 leaves `sci_en_o` unchanged and raises neither strobe.
- R6: A command-port write while `smi_cfg_en_i` = 1 raises `smi_o` in the next cycle for one cycle, whatever the value written.
- R7: A command-port write while `smi_cfg_en_i` = 0 leaves `smi_o` at 0.
- R8: A status-port write stores the byte only: `smi_o`, `sci_en_o` and both strobes stay unaffected, and the command port keeps its value.
- R9: Command writes in back-to-back cycles each produce their own SMI cycle, so `smi_o` stays high for as many cycles as there were writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| sel_i | input | 1 | Port select: 0 command, 1 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected port |
| smi_cfg_en_i | input | 1 | Configuration enable for SMI on command writes |
| sci_en_o | output | 1 | Current SCI enable state |
| sci_set_o | output | 1 | One-cycle strobe to set SCI enable in the control register |
| sci_clr_o | output | 1 | One-cycle strobe to clear SCI enable in the control register |
| smi_o | output | 1 | One-cycle system management interrupt pulse |

## Verification
The SCI enable change and the SMI pulse come from the same command write and show in the same cycle. The bench writes every byte value to the command port with the SMI enable high, and again with it low. In the cycle after each write it compares `smi_o`, both strobes and `sci_en_o` together against a model that tracks the enable state, and in the next cycle it confirms that the pulses have ended. Status-port sweeps run between command writes, so a leak of command side effects into status writes shows up as a changed enable or a stray pulse.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_PORTS = 2;
  localparam logic [BYTE_W-1:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [BYTE_W-1:0] CMD_SCI_OFF = 8'hF0;

  typedef enum logic {
    PORT_CMD    = 1'b0,
    PORT_STATUS = 1'b1
  } apm_port_e;
endpackage

// File: rtl/apm_byte_reg.sv
module apm_byte_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/apm_sci_ctl.sv
module apm_sci_ctl #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] ON_CODE  = 8'hF1,
  parameter logic [W-1:0] OFF_CODE = 8'hF0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_we_i,
  input  logic [W-1:0] d_i,
  output logic         sci_en_o,
  output logic         set_o,
  output logic         clr_o
);
  logic hit_on, hit_off;

  assign hit_on  = cmd_we_i && (d_i == ON_CODE);
  assign hit_off = cmd_we_i && (d_i == OFF_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_en_o <= 1'b0;
      set_o    <= 1'b0;
      clr_o    <= 1'b0;
    end else begin
      set_o <= hit_on;
      clr_o <= hit_off;
      if (hit_on)       sci_en_o <= 1'b1;
      else if (hit_off) sci_en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/apm_smi_gen.sv
module apm_smi_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_we_i,
  input  logic cfg_en_i,
  output logic smi_o
);
  // one pulse per qualifying write; consecutive writes keep it high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_o <= 1'b0;
    else         smi_o <= cmd_we_i && cfg_en_i;
  end
endmodule

// File: rtl/apm_port.sv
module apm_port
  import apm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              smi_cfg_en_i,
  output logic              sci_en_o,
  output logic              sci_set_o,
  output logic              sci_clr_o,
  output logic              smi_o
);
  logic [BYTE_W-1:0] port_q [N_PORTS];
  logic              cmd_we;

  assign cmd_we = wr_i && (apm_port_e'(sel_i) == PORT_CMD);

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    apm_byte_reg #(.W(BYTE_W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_i && (sel_i == 1'(g))),
      .d_i   (wdata_i),
      .q_o   (port_q[g])
    );
  end

  assign rdata_o = port_q[sel_i];

  apm_sci_ctl #(
    .W       (BYTE_W),
    .ON_CODE (CMD_SCI_ON),
    .OFF_CODE(CMD_SCI_OFF)
  ) u_sci (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we),
    .d_i     (wdata_i),
    .sci_en_o(sci_en_o),
    .set_o   (sci_set_o),
    .clr_o   (sci_clr_o)
  );

  apm_smi_gen u_smi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we),
    .cfg_en_i(smi_cfg_en_i),
    .smi_o   (smi_o)
  );
endmodule

// File: rtl/apm_port_chk.sv
module apm_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       sel_i,
  input logic [7:0] wdata_i,
  input logic       smi_cfg_en_i,
  input logic       sci_en_o,
  input logic       sci_set_o,
  input logic       sci_clr_o,
  input logic       smi_o
);
  assert_sci_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && wdata_i == 8'hF1) |=> (sci_en_o && sci_set_o && !sci_clr_o));

  assert_sci_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && wdata_i == 8'hF0) |=> (!sci_en_o && sci_clr_o && !sci_set_o));

  assert_sci_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !sel_i && (wdata_i == 8'hF0 || wdata_i == 8'hF1)) |=>
      ($stable(sci_en_o) && !sci_set_o && !sci_clr_o));

  assert_smi_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && smi_cfg_en_i) |=> smi_o);

  assert_smi_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !sel_i && smi_cfg_en_i) |=> !smi_o);

  assert_status_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> (!smi_o && !sci_set_o && !sci_clr_o && $stable(sci_en_o)));

  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sci_set_o && sci_clr_o));
endmodule

bind apm_port apm_port_chk u_apm_port_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .sel_i       (sel_i),
  .wdata_i     (wdata_i),
  .smi_cfg_en_i(smi_cfg_en_i),
  .sci_en_o    (sci_en_o),
  .sci_set_o   (sci_set_o),
  .sci_clr_o   (sci_clr_o),
  .smi_o       (smi_o)
);

// File: tb/apm_port_bench.sv
module apm_port_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       smi_cfg_en_i = 1'b0;
  logic       sci_en_o, sci_set_o, sci_clr_o, smi_o;

  int checks = 0;
  int errors = 0;
  logic       sci_exp = 1'b0;
  logic [7:0] cmd_exp = '0;
  logic [7:0] sts_exp = '0;

  always #4 clk_i = ~clk_i;

  apm_port u_apm_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .smi_cfg_en_i(smi_cfg_en_i),
    .sci_en_o(sci_en_o), .sci_set_o(sci_set_o), .sci_clr_o(sci_clr_o),
    .smi_o(smi_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_back(input string req);
    sel_i = 1'b0; #1;
    chk(req, 32'(rdata_o), 32'(cmd_exp));
    sel_i = 1'b1; #1;
    chk(req, 32'(rdata_o), 32'(sts_exp));
  endtask

  // write in one cycle, check side effects the next, then check pulses ended
  task automatic wr_byte(input logic s, input logic [7:0] d);
    logic on, off;
    on  = !s && d == 8'hF1;
    off = !s && d == 8'hF0;
    @(negedge clk_i);
    sel_i = s; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    if (s) sts_exp = d; else cmd_exp = d;
    if (on) sci_exp = 1'b1;
    if (off) sci_exp = 1'b0;
    if (s) begin
      chk("R8 smi", 32'(smi_o), 0);
      chk("R8 sci", 32'(sci_en_o), 32'(sci_exp));
      chk("R8 strobes", 32'({sci_set_o, sci_clr_o}), 0);
    end else begin
      chk(smi_cfg_en_i ? "R6 smi" : "R7 smi", 32'(smi_o), 32'(smi_cfg_en_i));
      chk(on ? "R3 sci" : off ? "R4 sci" : "R5 sci", 32'(sci_en_o), 32'(sci_exp));
      chk("R3 set", 32'(sci_set_o), 32'(on));
      chk("R4 clr", 32'(sci_clr_o), 32'(off));
    end
    read_back("R2 readback");
    @(negedge clk_i);
    chk("R6 pulse width", 32'({smi_o, sci_set_o, sci_clr_o}), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs", 32'({sci_en_o, sci_set_o, sci_clr_o, smi_o}), 0);
    read_back("R1 ports");
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int cfg = 0; cfg < 2; cfg++) begin
      smi_cfg_en_i = cfg[0];
      for (int v = 0; v < 256; v++) begin
        wr_byte(1'b0, 8'(v));
        wr_byte(1'b1, 8'(255 - v));
      end
    end

    // enable on, then status writes of the magic codes must not touch it (R8)
    smi_cfg_en_i = 1'b1;
    wr_byte(1'b0, 8'hF1);
    wr_byte(1'b1, 8'hF0);
    chk("R8 sci kept", 32'(sci_en_o), 1);
    wr_byte(1'b0, 8'h37);
    chk("R5 sci kept on", 32'(sci_en_o), 1);
    wr_byte(1'b0, 8'hF1);
    chk("R3 repeat set", 32'(sci_en_o), 1);

    // R9 back-to-back command writes
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b1; wdata_i = 8'h11;
    @(negedge clk_i);
    chk("R9 first", 32'(smi_o), 1);
    wdata_i = 8'hF0;
    @(negedge clk_i);
    chk("R9 second", 32'(smi_o), 1);
    wdata_i = 8'h22;
    @(negedge clk_i);
    wr_i = 1'b0;
    chk("R9 third", 32'(smi_o), 1);
    chk("R4 b2b clear", 32'(sci_en_o), 0);
    @(negedge clk_i);
    chk("R9 end", 32'(smi_o), 0);
    cmd_exp = 8'h22;
    read_back("R2 after b2b");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule